// File: doc/BRIEF.md
# Reconfigurable slot swap sequencer

This block replaces the module held in one partially reconfigurable slot with another while the static logic around the slot keeps running. A swap request carries three things: the target module number, the expected number of configuration words, and the requested length of the slot-local reset. The sequencer then performs a fixed series of steps:

- save the outgoing module's context, but only if that module keeps context;
- isolate the slot outputs;
- pass the incoming configuration words, one per accepted beat, to a word-wide configuration port with a write strobe;
- reset only the slot;
- restore the incoming module's context, but only if that module keeps context;
- release the isolation and acknowledge the swap.

A configuration stream whose length differs from the expected count ends the swap with an error. In that case the slot stays isolated until a new swap request succeeds. Which modules keep context is set by a per-module bit mask parameter. The current step is visible on a status output.

Top module: `slot_swap_seq`

## Requirements
- R1: `step_o` encodes the step as 0 idle, 1 save, 2 isolate, 3 load, 4 reset, 5 restore, 6 attach, 7 error. A swap visits the steps in that order. Step 1 is entered only when the outgoing module's bit in the context mask is set (default mask 4'b0101: modules 0 and 2 keep context).
- R2: `isolate_o` is high before the first configuration word is accepted. It stays high through the load, reset and restore steps. `cw_ready_o` is high only in the load step.
- R3: While `isolate_o` is high, `slot_out_o` is all zeros. Otherwise `slot_out_o` equals `slot_out_i`.
- R4: Each accepted word (`cw_valid_i` and `cw_ready_o` both high) appears on `cfg_data_o` with `cfg_we_o` high in the same cycle, in arrival order. No other cycle strobes `cfg_we_o`.
- R5: After a correct load, `slot_rst_o` is high for exactly max(`rst_len_i`, 4) consecutive cycles. `slot_rst_o` is high only while the slot is isolated.
- R6: The restore step follows the reset, and only when the incoming module's context mask bit is set.
- R7: Isolation is released at the attach step. `swap_ack_o` pulses for one cycle as isolation falls. `cur_mod_o` then shows the target module.
- R8: A request raised while a swap is in progress (steps 1 to 6) is ignored and starts no further swap.
- R9: If the word carrying `cw_last_i` is not word number `swap_len_i`, the sequencer enters step 7. It raises `swap_err_o`, pulses `swap_ack_o`, keeps `isolate_o` high and keeps `cur_mod_o` unchanged. A new request is accepted from step 7.
- R10: After reset the block is in step 0, with `isolate_o`, `slot_rst_o`, `cw_ready_o`, `cfg_we_o`, `swap_ack_o` and `swap_err_o` all low, and `cur_mod_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swap_req_i | input | 1 | Swap request |
| swap_tgt_i | input | MOD_W | Target module number |
| swap_len_i | input | CNT_W | Expected configuration word count |
| rst_len_i | input | RST_W | Requested slot reset length in cycles |
| swap_ack_o | output | 1 | One-cycle swap completion pulse |
| swap_err_o | output | 1 | Length mismatch on the last swap |
| cw_valid_i | input | 1 | Configuration word valid |
| cw_data_i | input | CFG_W | Configuration word |
| cw_last_i | input | 1 | Last word of the stream |
| cw_ready_o | output | 1 | Configuration word ready |
| cfg_data_o | output | CFG_W | Configuration port data |
| cfg_we_o | output | 1 | Configuration port write strobe |
| slot_out_i | input | SLOT_W | Raw slot outputs |
| slot_out_o | output | SLOT_W | Slot outputs as seen by static logic |
| isolate_o | output | 1 | Slot isolation active |
| slot_rst_o | output | 1 | Slot-local reset |
| save_req_o | output | 1 | Context save request |
| save_done_i | input | 1 | Context save finished |
| restore_req_o | output | 1 | Context restore request |
| restore_done_i | input | 1 | Context restore finished |
| step_o | output | 3 | Current step code |
| cur_mod_o | output | MOD_W | Module currently loaded |

## Verification
Swaps are run between every pairing of context and no-context modules, so that skipping the save step or the restore step shows up as a wrong step sequence. The word streams vary in form: a single word, a stream with a gap cycle, and a stream ended early against its declared length. These tell a correct length compare and a correct pass-through order apart from an off-by-one count. Reset lengths below, at and above the minimum of 4 separate the clamp from the plain count. A request pulsed in the middle of a load shows whether a busy request is dropped or restarts the sequence.

// File: rtl/slot_swap_pkg.sv
package slot_swap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SAVE = 3'd1,
    ST_ISO  = 3'd2,
    ST_LOAD = 3'd3,
    ST_RST  = 3'd4,
    ST_REST = 3'd5,
    ST_ATT  = 3'd6,
    ST_ERR  = 3'd7
  } step_e;
endpackage

// File: rtl/sss_word_ctr.sv
module sss_word_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  // current beat is word number len
  assign hit_o = (cnt_q + CNT_W'(1)) == len_i;
endmodule

// File: rtl/sss_rst_timer.sv
module sss_rst_timer #(
  parameter int RST_W   = 8,
  parameter int RST_MIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [RST_W-1:0] len_i,
  output logic             done_o
);
  logic [RST_W-1:0] cnt_q;
  logic [RST_W-1:0] eff;

  assign eff = (len_i < RST_W'(RST_MIN)) ? RST_W'(RST_MIN) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + RST_W'(1);
  end

  assign done_o = run_i && (cnt_q == eff - RST_W'(1));
endmodule

// File: rtl/sss_iso_gate.sv
module sss_iso_gate #(
  parameter int SLOT_W = 8
) (
  input  logic              iso_i,
  input  logic [SLOT_W-1:0] d_i,
  output logic [SLOT_W-1:0] q_o
);
  for (genvar b = 0; b < SLOT_W; b++) begin : g_bit
    assign q_o[b] = d_i[b] & ~iso_i;
  end
endmodule

// File: rtl/slot_swap_seq.sv
module slot_swap_seq
  import slot_swap_pkg::*;
#(
  parameter int          MOD_W    = 2,
  parameter int          CNT_W    = 16,
  parameter int          RST_W    = 8,
  parameter int          CFG_W    = 32,
  parameter int          SLOT_W   = 8,
  parameter int          RST_MIN  = 4,
  parameter logic [3:0]  CTX_MODS = 4'b0101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_req_i,
  input  logic [MOD_W-1:0]  swap_tgt_i,
  input  logic [CNT_W-1:0]  swap_len_i,
  input  logic [RST_W-1:0]  rst_len_i,
  output logic              swap_ack_o,
  output logic              swap_err_o,
  input  logic              cw_valid_i,
  input  logic [CFG_W-1:0]  cw_data_i,
  input  logic              cw_last_i,
  output logic              cw_ready_o,
  output logic [CFG_W-1:0]  cfg_data_o,
  output logic              cfg_we_o,
  input  logic [SLOT_W-1:0] slot_out_i,
  output logic [SLOT_W-1:0] slot_out_o,
  output logic              isolate_o,
  output logic              slot_rst_o,
  output logic              save_req_o,
  input  logic              save_done_i,
  output logic              restore_req_o,
  input  logic              restore_done_i,
  output logic [2:0]        step_o,
  output logic [MOD_W-1:0]  cur_mod_o
);
  localparam int NUM_MODS = 1 << MOD_W;

  step_e            state_q, state_d;
  logic [MOD_W-1:0] tgt_q, cur_q;
  logic [CNT_W-1:0] len_q;
  logic [RST_W-1:0] rlen_q;
  logic             iso_q, ack_q, err_q;
  logic             accept, beat, len_hit, rst_done, mismatch;
  logic [NUM_MODS-1:0] ctx_mask;

  assign ctx_mask = NUM_MODS'(CTX_MODS);
  assign accept   = swap_req_i && (state_q == ST_IDLE || state_q == ST_ERR);
  assign beat     = cw_valid_i && cw_ready_o;
  assign mismatch = beat && cw_last_i && !len_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_ERR: if (accept) state_d = ctx_mask[cur_q] ? ST_SAVE : ST_ISO;
      ST_SAVE: if (save_done_i) state_d = ST_ISO;
      ST_ISO:  state_d = ST_LOAD;
      ST_LOAD: if (beat && cw_last_i) state_d = len_hit ? ST_RST : ST_ERR;
      ST_RST:  if (rst_done) state_d = ctx_mask[tgt_q] ? ST_REST : ST_ATT;
      ST_REST: if (restore_done_i) state_d = ST_ATT;
      ST_ATT:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      cur_q   <= '0;
      len_q   <= '0;
      rlen_q  <= '0;
      iso_q   <= 1'b0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_q == ST_ATT) || mismatch;
      if (accept) begin
        tgt_q  <= swap_tgt_i;
        len_q  <= swap_len_i;
        rlen_q <= rst_len_i;
        err_q  <= 1'b0;
      end
      if (mismatch) err_q <= 1'b1;
      if (state_q == ST_LOAD && state_d == ST_RST) cur_q <= tgt_q;
      if (state_d == ST_ISO) iso_q <= 1'b1;
      else if (state_q == ST_ATT) iso_q <= 1'b0;
    end
  end

  sss_word_ctr #(.CNT_W(CNT_W)) u_wctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .inc_i (beat),
    .len_i (len_q),
    .hit_o (len_hit)
  );

  sss_rst_timer #(.RST_W(RST_W), .RST_MIN(RST_MIN)) u_rtmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_RST),
    .len_i (rlen_q),
    .done_o(rst_done)
  );

  sss_iso_gate #(.SLOT_W(SLOT_W)) u_gate (
    .iso_i(iso_q),
    .d_i  (slot_out_i),
    .q_o  (slot_out_o)
  );

  assign cw_ready_o    = (state_q == ST_LOAD);
  assign cfg_we_o      = beat;
  assign cfg_data_o    = cw_data_i;
  assign isolate_o     = iso_q;
  assign slot_rst_o    = (state_q == ST_RST);
  assign save_req_o    = (state_q == ST_SAVE);
  assign restore_req_o = (state_q == ST_REST);
  assign swap_ack_o    = ack_q;
  assign swap_err_o    = err_q;
  assign step_o        = state_q;
  assign cur_mod_o     = cur_q;
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
  parameter int SLOT_W  = 8,
  parameter int CFG_W   = 32,
  parameter int RST_MIN = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              swap_req_i,
  input logic              cw_valid_i,
  input logic [CFG_W-1:0]  cw_data_i,
  input logic              cw_ready_o,
  input logic              cfg_we_o,
  input logic [SLOT_W-1:0] slot_out_i,
  input logic [SLOT_W-1:0] slot_out_o,
  input logic              isolate_o,
  input logic              slot_rst_o,
  input logic              restore_req_o,
  input logic              swap_ack_o,
  input logic              swap_err_o,
  input logic [2:0]        step_o
);
  logic [15:0] rst_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rst_run_q <= '0;
    else if (slot_rst_o) rst_run_q <= rst_run_q + 16'd1;
    else                 rst_run_q <= '0;
  end

  assert_ready_isolated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_ready_o |-> isolate_o);
  assert_gate_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isolate_o |-> slot_out_o == '0);
  assert_gate_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isolate_o |-> slot_out_o == slot_out_i);
  assert_we_beat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> (cw_valid_i && cw_ready_o));
  assert_rst_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slot_rst_o) |-> rst_run_q >= 16'(RST_MIN));
  assert_rst_isolated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_rst_o |-> isolate_o);
  assert_restore_after_rst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_req_o) |-> $past(slot_rst_o));
  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_ack_o |=> !swap_ack_o);
  assert_release_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(isolate_o) |-> swap_ack_o);
  assert_busy_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_req_i && step_o inside {3'd3, 3'd4, 3'd5}) |=> !(step_o inside {3'd1, 3'd2}));
  assert_err_isolated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_err_o |-> isolate_o);
endmodule

bind slot_swap_seq sss_checker #(.SLOT_W(SLOT_W), .CFG_W(CFG_W), .RST_MIN(RST_MIN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .swap_req_i   (swap_req_i),
  .cw_valid_i   (cw_valid_i),
  .cw_data_i    (cw_data_i),
  .cw_ready_o   (cw_ready_o),
  .cfg_we_o     (cfg_we_o),
  .slot_out_i   (slot_out_i),
  .slot_out_o   (slot_out_o),
  .isolate_o    (isolate_o),
  .slot_rst_o   (slot_rst_o),
  .restore_req_o(restore_req_o),
  .swap_ack_o   (swap_ack_o),
  .swap_err_o   (swap_err_o),
  .step_o       (step_o)
);

// File: tb/sim_slot_swap_seq.sv
module sim_slot_swap_seq;
  localparam int CLK_P = 10;
  localparam logic [3:0] CTX = 4'b0101;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        swap_req_i = 1'b0;
  logic [1:0]  swap_tgt_i = '0;
  logic [15:0] swap_len_i = '0;
  logic [7:0]  rst_len_i = '0;
  logic        swap_ack_o, swap_err_o;
  logic        cw_valid_i = 1'b0;
  logic [31:0] cw_data_i = '0;
  logic        cw_last_i = 1'b0;
  logic        cw_ready_o;
  logic [31:0] cfg_data_o;
  logic        cfg_we_o;
  logic [7:0]  slot_out_i = 8'hA5;
  logic [7:0]  slot_out_o;
  logic        isolate_o, slot_rst_o, save_req_o, restore_req_o;
  logic        save_done_i = 1'b0, restore_done_i = 1'b0;
  logic [2:0]  step_o;
  logic [1:0]  cur_mod_o;

  int checks = 0, errors = 0;
  logic [2:0]  step_q[$];
  logic [31:0] data_q[$];
  logic [2:0]  prev_step = 3'd0;
  int          rst_run = 0, rst_exp = 4;
  logic [1:0]  cur = 2'd0;

  always #(CLK_P/2) clk_i = ~clk_i;

  slot_swap_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: step order, config words, reset length
  always @(negedge clk_i) if (rst_ni) begin
    if (step_o != prev_step) begin
      if (step_q.size() == 0) chk(0, "R1", "unexpected step", step_o, -1);
      else begin
        logic [2:0] e;
        e = step_q.pop_front();
        chk(step_o == e, "R1", "step order", step_o, e);
      end
      prev_step = step_o;
    end
    if (cfg_we_o) begin
      if (data_q.size() == 0) chk(0, "R4", "unexpected cfg write", cfg_data_o, -1);
      else begin
        logic [31:0] e;
        e = data_q.pop_front();
        chk(cfg_data_o == e, "R4", "cfg word", cfg_data_o, e);
      end
      chk(isolate_o && slot_out_o == 8'h00, "R2", "isolated during load", {isolate_o, slot_out_o}, 256);
    end
    if (slot_rst_o) begin
      rst_run++;
      if (!isolate_o) chk(0, "R5", "reset while attached", 0, 1);
    end else if (rst_run > 0) begin
      chk(rst_run == rst_exp, "R5", "slot reset length", rst_run, rst_exp);
      rst_run = 0;
    end
  end

  // context handshake responder
  initial forever begin
    @(negedge clk_i);
    if (save_req_o || restore_req_o) begin
      repeat (2) @(negedge clk_i);
      if (save_req_o) save_done_i = 1'b1;
      if (restore_req_o) restore_done_i = 1'b1;
      @(negedge clk_i);
      save_done_i = 1'b0;
      restore_done_i = 1'b0;
    end
  end

  task automatic do_swap(input logic [1:0] tgt, input int nw, input int dlen,
                         input int rlen, input bit exp_err, input bit inject);
    // expected step sequence (R1, R6)
    if (CTX[cur]) step_q.push_back(3'd1);
    step_q.push_back(3'd2);
    step_q.push_back(3'd3);
    if (exp_err) step_q.push_back(3'd7);
    else begin
      step_q.push_back(3'd4);
      if (CTX[tgt]) step_q.push_back(3'd5);
      step_q.push_back(3'd6);
      step_q.push_back(3'd0);
    end
    rst_exp = (rlen < 4) ? 4 : rlen;
    @(negedge clk_i);
    swap_req_i = 1'b1; swap_tgt_i = tgt; swap_len_i = 16'(dlen); rst_len_i = 8'(rlen);
    @(negedge clk_i);
    swap_req_i = 1'b0;
    while (!cw_ready_o) @(negedge clk_i);
    for (int i = 0; i < nw; i++) begin
      cw_valid_i = 1'b1;
      cw_data_i  = {tgt, 22'h0, 8'(i)} ^ 32'h5A00_0000;
      cw_last_i  = (i == nw - 1);
      data_q.push_back(cw_data_i);
      if (inject && i == 0) begin swap_req_i = 1'b1; swap_tgt_i = 2'd3; end
      @(negedge clk_i);
      swap_req_i = 1'b0;
      if (i == 1) begin cw_valid_i = 1'b0; @(negedge clk_i); end
    end
    cw_valid_i = 1'b0; cw_last_i = 1'b0;
    while (!swap_ack_o) @(negedge clk_i);
    @(negedge clk_i);
    #1;
    chk(swap_err_o == exp_err, exp_err ? "R9" : "R7", "error flag", swap_err_o, exp_err);
    chk(isolate_o == exp_err, exp_err ? "R9" : "R7", "isolate after ack", isolate_o, exp_err);
    chk(slot_out_o == (exp_err ? 8'h00 : slot_out_i), "R3", "slot outputs", slot_out_o,
        exp_err ? 0 : slot_out_i);
    if (!exp_err) cur = tgt;
    chk(cur_mod_o == cur, exp_err ? "R9" : "R7", "current module", cur_mod_o, cur);
    chk(step_q.size() == 0 && data_q.size() == 0, "R1", "steps and words consumed",
        step_q.size() + data_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // r10_ reset state
    chk(step_o == 3'd0 && !isolate_o && !slot_rst_o && !cw_ready_o && !cfg_we_o &&
        !swap_ack_o && !swap_err_o && cur_mod_o == 2'd0, "R10", "reset state", step_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(slot_out_o == slot_out_i, "R3", "pass-through when attached", slot_out_o, slot_out_i);

    do_swap(2'd1, 6, 6, 2, 1'b0, 1'b0);  // save, no restore, reset clamped (R5)
    do_swap(2'd2, 3, 3, 7, 1'b0, 1'b1);  // no save, restore, busy request (R8)
    repeat (5) @(negedge clk_i);
    chk(step_o == 3'd0 && cur_mod_o == 2'd2, "R8", "busy request ignored", step_o, 0);
    do_swap(2'd3, 4, 5, 4, 1'b1, 1'b0);  // short stream -> error (R9)
    repeat (4) @(negedge clk_i);
    chk(step_o == 3'd7 && isolate_o, "R9", "error holds isolation", step_o, 7);
    do_swap(2'd3, 5, 5, 4, 1'b0, 1'b0);  // retry from error
    do_swap(2'd0, 1, 1, 0, 1'b0, 1'b0);  // single word, restore (R6)
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule